// File: doc/BRIEF.md
# Serial Frame Transmitter with Byte Queue

This block turns bytes supplied by a host into asynchronous serial frames on one output wire. Bytes enter through a valid/ready port into a 16-deep, 8-bit queue. A serializer takes the oldest byte, builds a frame and shifts it out. The frame has a low start bit, 5 to 8 data bits sent least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from an external baud tick. Every bit lasts sixteen ticks.

Two enables gate the traffic: a block enable and a transmit enable. A new frame starts only while both are set. Clearing either one never truncates a frame: the frame in progress runs to its last stop bit, then the serializer stops taking queue entries. The frame configuration is captured when a frame starts, so a change to it never alters the frame on the wire. The host sees the queue full and empty flags, a busy flag and a sticky overflow flag.

Top module: `serial_tx_queue`

## Requirements
- R1: After reset `serial_out` is 1, `empty` is 1, `full`, `busy` and `ovf` are 0, and `in_ready` is 1.
- R2: The queue takes 16 bytes. With 16 entries held, `full` is 1 and `in_ready` is 0. Bytes leave in the order they were written.
- R3: A write while `full` is 1 is dropped and sets `ovf`. `ovf` stays set until a cycle with `ovf_clear` high and no new dropped write. A dropped write in the same cycle keeps it set.
- R4: A frame is a start bit of 0, then the data bits LSB first, then the stop bits of 1. Each bit holds for 16 rising edges of `tick`. The line changes in the cycle after the 16th tick.
- R5: `cfg_len` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Byte bits above the length are neither sent nor counted in parity.
- R6: With `cfg_parity_en` at 1, one parity bit follows the data. `cfg_parity_mode` 00 gives even parity and 01 gives odd parity. 10 gives a constant 0 and 11 gives a constant 1.
- R7: `cfg_stop2` at 0 gives one stop bit and at 1 gives two.
- R8: While `enable` or `tx_enable` is 0, no frame starts and the queue keeps its entries.
- R9: Clearing an enable during a frame lets that frame finish in full. No further entry is taken after it.
- R10: The configuration is sampled when a frame starts. Later changes do not affect that frame.
- R11: When a byte is waiting and both enables are set, the next start bit directly follows the last stop bit, with no idle bit time.
- R12: `busy` is 1 while a frame is on the line, and also while the queue is not empty and both enables are set. Otherwise it is 0.
- R13: Between frames the line idles at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable |
| tx_enable | input | 1 | Transmit enable |
| tick | input | 1 | Baud tick, one clock wide, 16 per bit |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_mode | input | 2 | Parity kind: even, odd, constant 0, constant 1 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| in_valid | input | 1 | Host write strobe |
| in_data | input | 8 | Byte to queue |
| in_ready | output | 1 | Queue can accept a byte |
| ovf_clear | input | 1 | Clears the overflow flag |
| serial_out | output | 1 | Serial line |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| busy | output | 1 | Transmit activity flag |
| ovf | output | 1 | Sticky dropped-write flag |

## Verification
The assertions check several things on every cycle: the queue occupancy bound, that a write into a full queue never raises the occupancy, that the overflow flag is sticky, and that the line stays steady between ticks during a frame. They also check that the line is at 1 whenever the serializer is idle, that it is low during a start bit, and that the queue does not move while disabled with no writes. The bit order of each frame, the parity value for every mode and length, and the absence of a gap between frames can only be shown by the bench's scenarios. The same applies to the completion of a frame after an enable is cleared and to the immunity to mid-frame configuration changes. For these, the bench's behavioural model predicts the line on every clock and compares it with the design.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [1:0] {
    PAR_EVEN = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_ZERO = 2'b10,
    PAR_ONE  = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    par_mode_e  par_mode;
    logic       stop2;
  } frame_cfg_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             ovf_clear,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic             ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             wr_en;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_en = wr_valid && !full;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (wr_valid && full) ovf <= 1'b1;
      else if (ovf_clear)   ovf <= 1'b0;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r3_no_growth_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && wr_valid) |=> (cnt <= $past(cnt)));
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clear) |=> ovf);
endmodule

// File: rtl/txq_serializer.sv
module txq_serializer
  import serial_tx_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int TICKS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             tick,
  input  frame_cfg_t       cfg,
  input  logic             avail,
  input  logic [WIDTH-1:0] head,
  output logic             pop,
  output logic             txd,
  output logic             active
);
  localparam int TW = $clog2(TICKS);
  localparam int IW = $clog2(WIDTH);

  tx_state_e        state;
  logic [TW-1:0]    tcnt;
  logic [IW-1:0]    bidx, last_idx, new_last;
  logic [WIDTH-1:0] sreg, mask;
  frame_cfg_t       cfg_q;
  logic             par_q, par_calc, stop_more, bit_done, frame_end;

  assign bit_done  = tick && (tcnt == TW'(TICKS-1));
  assign frame_end = (state == S_STOP) && bit_done && !stop_more;
  assign pop       = go && avail && ((state == S_IDLE) || frame_end);
  assign active    = (state != S_IDLE);
  assign last_idx  = IW'(WIDTH-4) + IW'(cfg_q.len);
  assign new_last  = IW'(WIDTH-4) + IW'(cfg.len);

  always_comb begin
    for (int i = 0; i < WIDTH; i++) mask[i] = (i <= int'(new_last));
    case (cfg.par_mode)
      PAR_EVEN: par_calc = ^(head & mask);
      PAR_ODD:  par_calc = ~(^(head & mask));
      PAR_ZERO: par_calc = 1'b0;
      default:  par_calc = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      sreg      <= '0;
      cfg_q     <= '0;
      par_q     <= 1'b0;
      stop_more <= 1'b0;
      txd       <= 1'b1;
    end else if (pop) begin
      state <= S_START;
      txd   <= 1'b0;
      tcnt  <= '0;
      sreg  <= head;
      cfg_q <= cfg;
      par_q <= par_calc;
    end else begin
      if (state != S_IDLE && tick) tcnt <= bit_done ? '0 : tcnt + TW'(1);
      if (bit_done) begin
        case (state)
          S_START: begin
            state <= S_DATA;
            txd   <= sreg[0];
            sreg  <= sreg >> 1;
            bidx  <= '0;
          end
          S_DATA: begin
            if (bidx == last_idx) begin
              if (cfg_q.par_en) begin
                state <= S_PAR;
                txd   <= par_q;
              end else begin
                state     <= S_STOP;
                txd       <= 1'b1;
                stop_more <= cfg_q.stop2;
              end
            end else begin
              bidx <= bidx + IW'(1);
              txd  <= sreg[0];
              sreg <= sreg >> 1;
            end
          end
          S_PAR: begin
            state     <= S_STOP;
            txd       <= 1'b1;
            stop_more <= cfg_q.stop2;
          end
          S_STOP: begin
            if (stop_more) stop_more <= 1'b0;
            else begin
              state <= S_IDLE;
              txd   <= 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r13_idle_high: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> txd);
  a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
    (state == S_START) |-> !txd);
  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && !tick) |=> $stable(txd));
endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue
  import serial_tx_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int TICKS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tx_enable,
  input  logic             tick,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_parity_en,
  input  logic [1:0]       cfg_parity_mode,
  input  logic             cfg_stop2,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             ovf_clear,
  output logic             serial_out,
  output logic             full,
  output logic             empty,
  output logic             busy,
  output logic             ovf
);
  logic             go, pop, active;
  logic [WIDTH-1:0] head;
  frame_cfg_t       cfg;

  assign go  = enable && tx_enable;
  assign cfg = '{len: cfg_len, par_en: cfg_parity_en,
                 par_mode: par_mode_e'(cfg_parity_mode), stop2: cfg_stop2};

  txq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_valid(in_valid), .wr_data(in_data),
    .rd_en(pop), .ovf_clear(ovf_clear), .rd_data(head),
    .full(full), .empty(empty), .ovf(ovf)
  );

  txq_serializer #(.WIDTH(WIDTH), .TICKS(TICKS)) u_ser (
    .clk(clk), .rst(rst), .go(go), .tick(tick), .cfg(cfg),
    .avail(!empty), .head(head), .pop(pop), .txd(serial_out), .active(active)
  );

  assign in_ready = !full;
  assign busy     = active || (!empty && go);

  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!go && !in_valid) |=> $stable(empty));
  a_r12_busy_in_frame: assert property (@(posedge clk) disable iff (rst)
    (!serial_out) |-> busy);
endmodule

// File: tb/sim_serial_tx_queue.sv
module sim_serial_tx_queue;
  logic clk = 1'b0, rst = 1'b1;
  logic enable = 1'b0, tx_enable = 1'b1, tick = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_parity_mode = 2'd0;
  logic cfg_parity_en = 1'b0, cfg_stop2 = 1'b0;
  logic in_valid = 1'b0, ovf_clear = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, serial_out, full, empty, busy, ovf;

  always #5 clk = ~clk;

  serial_tx_queue u0 (
    .clk(clk), .rst(rst), .enable(enable), .tx_enable(tx_enable), .tick(tick),
    .cfg_len(cfg_len), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_mode(cfg_parity_mode), .cfg_stop2(cfg_stop2),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ovf_clear(ovf_clear), .serial_out(serial_out), .full(full),
    .empty(empty), .busy(busy), .ovf(ovf)
  );

  int checks = 0, failures = 0, cycles = 0, tdiv = 0;
  string cur_req = "R4";

  // behavioural reference model
  int  q[$];
  bit  m_frame[16];
  int  m_len = 0, m_pos = 0, m_tc = 0, pre = 0, bval = 0, nb = 0;
  bit  m_act = 1'b0, m_ovf = 1'b0, pb = 1'b0;

  always @(posedge clk) begin
    #1;
    if (rst) tdiv = 0;
    else tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 3);
  end

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_act = 0; m_ovf = 0; m_pos = 0; m_tc = 0;
    end else begin
      pre = q.size();
      if (m_act && tick) begin
        m_tc++;
        if (m_tc == 16) begin
          m_tc = 0; m_pos++;
          if (m_pos == m_len) m_act = 0;
        end
      end
      if (!m_act && enable && tx_enable && pre > 0) begin
        bval = q.pop_front();
        nb = 5 + int'(cfg_len);
        m_len = 0;
        m_frame[m_len++] = 1'b0;
        pb = 1'b0;
        for (int i = 0; i < nb; i++) begin
          m_frame[m_len++] = bval[i];
          pb = pb ^ bval[i];
        end
        if (cfg_parity_en) begin
          case (cfg_parity_mode)
            2'd0: m_frame[m_len++] = pb;
            2'd1: m_frame[m_len++] = ~pb;
            2'd2: m_frame[m_len++] = 1'b0;
            default: m_frame[m_len++] = 1'b1;
          endcase
        end
        m_frame[m_len++] = 1'b1;
        if (cfg_stop2) m_frame[m_len++] = 1'b1;
        m_act = 1; m_pos = 0; m_tc = 0;
      end
      if (in_valid) begin
        if (pre < 16) q.push_back(int'(in_data));
        else m_ovf = 1;
      end
      if (ovf_clear && !(in_valid && pre == 16)) m_ovf = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (!rst) begin
      chk(serial_out == (m_act ? m_frame[m_pos] : 1'b1), cur_req,
          int'(serial_out), int'(m_act ? m_frame[m_pos] : 1'b1));
      chk(busy == (m_act || (q.size() > 0 && enable && tx_enable)), "R12",
          int'(busy), int'(m_act || (q.size() > 0 && enable && tx_enable)));
      chk(empty == (q.size() == 0), "R2 empty", int'(empty), int'(q.size() == 0));
      chk(full == (q.size() == 16), "R2 full", int'(full), int'(q.size() == 16));
      chk(in_ready == (q.size() != 16), "R2 ready", int'(in_ready), int'(q.size() != 16));
      chk(ovf == m_ovf, "R3 ovf", int'(ovf), int'(m_ovf));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] b);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((m_act || q.size() > 0) && n < 30000) begin
      step(1); n++;
    end
    step(3);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    @(negedge clk);
    chk(serial_out == 1'b1, "R1 line", int'(serial_out), 1);
    chk(empty && !full && !busy && !ovf && in_ready, "R1 flags",
        int'({empty, full, busy, ovf, in_ready}), 5'b10001);

    cur_req = "R8";
    push(8'h3C); push(8'hC5); push(8'h81);
    step(300);
    @(negedge clk);
    chk(serial_out == 1'b1 && !empty, "R8 held", int'({serial_out, empty}), 2'b10);
    enable = 1'b1; tx_enable = 1'b0;
    step(300);
    @(negedge clk);
    chk(serial_out == 1'b1 && !empty, "R8 tx off", int'({serial_out, empty}), 2'b10);

    cur_req = "R11";  // 8 data bits, back-to-back frames
    tx_enable = 1'b1;
    wait_idle();
    chk(empty == 1'b1, "R4 drained", int'(empty), 1);

    cur_req = "R6";
    cfg_parity_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      cfg_parity_mode = 2'(m);
      for (int l = 0; l < 4; l++) begin
        cur_req = (l < 3) ? "R5" : "R6";
        cfg_len = 2'(l);
        push(8'hE9 ^ 8'(m * 37));
        wait_idle();
      end
    end

    cur_req = "R7";
    cfg_stop2 = 1'b1; cfg_len = 2'd2; cfg_parity_mode = 2'd1;
    push(8'h5A); push(8'hF0);
    wait_idle();

    cur_req = "R10";
    cfg_stop2 = 1'b0; cfg_parity_en = 1'b0; cfg_len = 2'd3;
    push(8'hA5);
    step(200);
    cfg_len = 2'd0; cfg_parity_en = 1'b1; cfg_stop2 = 1'b1; cfg_parity_mode = 2'd3;
    wait_idle();
    cfg_len = 2'd3; cfg_parity_en = 1'b0; cfg_stop2 = 1'b0;

    cur_req = "R9";
    push(8'h96); push(8'h69);
    step(300);
    enable = 1'b0;
    step(1500);
    @(negedge clk);
    chk(!empty && serial_out && !busy, "R9 stopped",
        int'({empty, serial_out, busy}), 3'b010);
    enable = 1'b1;
    wait_idle();

    cur_req = "R13";
    enable = 1'b0;
    for (int i = 0; i < 17; i++) push(8'(i * 13 + 1));
    @(negedge clk);
    chk(full && !in_ready, "R2 sixteen", int'({full, in_ready}), 2'b10);
    chk(ovf == 1'b1, "R3 set", int'(ovf), 1);
    step(5);
    @(negedge clk);
    chk(ovf == 1'b1, "R3 sticky", int'(ovf), 1);
    @(posedge clk); #1;
    ovf_clear = 1'b1;
    @(posedge clk); #1;
    ovf_clear = 1'b0;
    @(negedge clk);
    chk(ovf == 1'b0, "R3 cleared", int'(ovf), 0);
    cur_req = "R2 order";
    enable = 1'b1;
    wait_idle();
    @(negedge clk);
    chk(serial_out && empty && !busy, "R13 idle", int'({serial_out, empty, busy}), 3'b110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule